// File: doc/BRIEF.md
# Nested Three-Level Interrupt Priority Controller

This block arbitrates among six interrupt sources and tracks how far interrupt service routines are nested. The six sources are a power-fail warning, two external interrupts, two timer overflows and one serial request. The serial request is the OR of a receive flag and a transmit flag. The power-fail warning always sits on a fixed top level. Each of the other five sources sits on a high or a low level, chosen by one bit of a 5-bit priority register that software can write and read back.

Each cycle the controller works out which pending, enabled source may preempt the routine now in service. When one may, it issues a one-cycle acknowledge with a 3-bit vector index and marks that source's level as in service. The CPU signals the end of a routine with a return strobe. That strobe retires the innermost level, so the preempted routine's level becomes current again. The controller never clears a source flag; the peripheral that raised it does that.

The asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While reset is held, and until the first write after it, the priority register reads 0. No level is in service (`svc_level` = 0), `ack` is 0 and `vec_idx` is 0.
- R2: When `prio_wr` is 1 on a clock edge, the register takes `prio_wdata` at that edge and `prio_rdata` shows it from then on. Bit 0 belongs to external interrupt 0, bit 1 to timer 0, bit 2 to external interrupt 1, bit 3 to timer 1 and bit 4 to the serial source.
- R3: Levels are encoded 0 = none, 1 = low, 2 = high, 3 = power-fail. The power-fail source is always level 3. Every other source is level 2 when its priority bit is 1 and level 1 when its bit is 0.
- R4: A source is eligible only when all of these hold: its flag is 1, its `src_en` bit is 1, `glb_en` is 1, and its level is strictly greater than `svc_level`. The `src_en` bit index is the same as the vector index. It follows that a routine cannot be preempted by a request of its own level or of any lower level.
- R5: Among eligible sources, one on a higher level is always chosen over one on a lower level.
- R6: Ties within a level go to the lowest vector index. Vector indices are 0 power-fail, 1 external interrupt 0, 2 timer 0, 3 external interrupt 1, 4 timer 1, 5 serial. The serial request is `rx_flag | tx_flag`.
- R7: Inputs sampled at one clock edge produce `ack` and `vec_idx` just after that edge. `ack` is 1 for exactly the cycles that follow a decision in which some source was eligible. `vec_idx` is 0 whenever `ack` is 0.
- R8: The edge that raises `ack` also marks the granted level as in service. `svc_level` always reports the highest level in service.
- R9: A `reti` pulse sampled at an edge retires the highest level in service, and any lower levels stay in service. A `reti` with nothing in service has no effect. If a grant happens at the same edge, the retire still applies to the level that was highest before that grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 6 | Per-source enable, indexed by vector index |
| pfw_flag | input | 1 | Power-fail warning request |
| ext0_flag | input | 1 | External interrupt 0 request |
| tmr0_flag | input | 1 | Timer 0 overflow request |
| ext1_flag | input | 1 | External interrupt 1 request |
| tmr1_flag | input | 1 | Timer 1 overflow request |
| rx_flag | input | 1 | Serial receive request |
| tx_flag | input | 1 | Serial transmit request |
| reti | input | 1 | Return-from-interrupt strobe |
| prio_wr | input | 1 | Priority register write enable |
| prio_wdata | input | 5 | Priority register write data |
| prio_rdata | output | 5 | Priority register contents |
| ack | output | 1 | Acknowledge pulse |
| vec_idx | output | 3 | Granted vector index |
| svc_level | output | 2 | Highest level in service |

## Verification
The first sweep covers all 32 priority settings against all 64 request patterns, starting from an idle controller. Because every pattern arrives at once, this separates the level-first choice from the fixed index order, and it checks that a held request is not granted a second time. Alternating the serial request between the receive and transmit flags shows that both reach the serial slot. A second, long pseudo-random run staggers arrivals, return strobes, priority writes and enable changes. That run builds real nesting: a low routine is preempted by a high one, and then by power-fail. It also covers the order in which returns unwind those levels, and grants and returns that land on the same edge.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NUM_SRC = 6;
  localparam int PRIO_W  = NUM_SRC - 1;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int NUM_LVL = 3;
  localparam int LVL_W   = $clog2(NUM_LVL + 1);

  typedef enum logic [LVL_W-1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_PFW  = 2'd3
  } lvl_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/irq_prio_reg.sv
module irq_prio_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= '0;
    else if (wr_en) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_nest_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               glb_en,
  input  logic [PRIO_W-1:0]  prio,
  input  lvl_e               cur_lvl,
  output logic               grant,
  output logic [IDX_W-1:0]   grant_idx,
  output lvl_e               grant_lvl
);
  lvl_e               src_lvl [NUM_SRC];
  logic [NUM_SRC-1:0] elig;

  // Source 0 is fixed on the top level; the rest take their level from one register bit.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (g == 0) begin : g_fixed
      assign src_lvl[g] = LVL_PFW;
    end else begin : g_prog
      assign src_lvl[g] = prio[g-1] ? LVL_HIGH : LVL_LOW;
    end
    assign elig[g] = pend[g] & src_en[g] & glb_en & (src_lvl[g] > cur_lvl);
  end

  // A strict comparison keeps the lowest index when two sources share a level.
  always_comb begin
    grant_lvl = LVL_NONE;
    grant_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (src_lvl[i] > grant_lvl)) begin
        grant_lvl = src_lvl[i];
        grant_idx = IDX_W'(i);
      end
    end
    grant = (grant_lvl != LVL_NONE);
  end
endmodule

// File: rtl/isr_nest_stack.sv
module isr_nest_stack
  import irq_nest_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reti,
  input  logic grant,
  input  lvl_e grant_lvl,
  output lvl_e svc_lvl
);
  logic [NUM_LVL-1:0] isf_q;
  logic [NUM_LVL-1:0] isf_d;
  logic [NUM_LVL-1:0] top_oh;
  logic [NUM_LVL-1:0] set_oh;
  logic               upd;

  // One-hot marker of the innermost (highest) level in service.
  always_comb begin
    top_oh = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (isf_q[i] && (top_oh == '0)) top_oh[i] = 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_set
    assign set_oh[g] = grant && (LVL_W'(grant_lvl) == LVL_W'(g + 1));
  end

  // Retire the level that was highest before this edge, then mark the new grant.
  always_comb begin
    isf_d = (isf_q & ~(reti ? top_oh : '0)) | set_oh;
    upd   = reti | grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   isf_q <= '0;
    else if (upd) isf_q <= isf_d;
  end

  always_comb begin
    svc_lvl = LVL_NONE;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (isf_q[i]) svc_lvl = lvl_e'(LVL_W'(i + 1));
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               pfw_flag,
  input  logic               ext0_flag,
  input  logic               tmr0_flag,
  input  logic               ext1_flag,
  input  logic               tmr1_flag,
  input  logic               rx_flag,
  input  logic               tx_flag,
  input  logic               reti,
  input  logic               prio_wr,
  input  logic [PRIO_W-1:0]  prio_wdata,
  output logic [PRIO_W-1:0]  prio_rdata,
  output logic               ack,
  output logic [IDX_W-1:0]   vec_idx,
  output logic [LVL_W-1:0]   svc_level
);
  logic               rst_n_s;
  logic [NUM_SRC-1:0] pend;
  logic [PRIO_W-1:0]  prio_q;
  lvl_e               svc_lvl;
  logic               grant;
  logic [IDX_W-1:0]   grant_idx;
  lvl_e               grant_lvl;
  logic               ack_q, ack_d;
  logic [IDX_W-1:0]   vec_q, vec_d;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // Pending vector, indexed by vector number.
  assign pend = {rx_flag | tx_flag, tmr1_flag, ext1_flag, tmr0_flag, ext0_flag, pfw_flag};

  irq_prio_reg #(.W(PRIO_W)) u_prio (
    .clk   (clk),
    .rst_n (rst_n_s),
    .wr_en (prio_wr),
    .wdata (prio_wdata),
    .q     (prio_q)
  );

  irq_arbiter u_arb (
    .pend      (pend),
    .src_en    (src_en),
    .glb_en    (glb_en),
    .prio      (prio_q),
    .cur_lvl   (svc_lvl),
    .grant     (grant),
    .grant_idx (grant_idx),
    .grant_lvl (grant_lvl)
  );

  isr_nest_stack u_nest (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .reti      (reti),
    .grant     (grant),
    .grant_lvl (grant_lvl),
    .svc_lvl   (svc_lvl)
  );

  always_comb begin
    ack_d = grant;
    vec_d = grant ? grant_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= ack_d;
      vec_q <= vec_d;
    end
  end

  assign prio_rdata = prio_q;
  assign ack        = ack_q;
  assign vec_idx    = vec_q;
  assign svc_level  = LVL_W'(svc_lvl);
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       glb_en,
  input logic       reti,
  input logic [4:0] prio_rdata,
  input logic       ack,
  input logic [2:0] vec_idx,
  input logic [1:0] svc_level
);
  function automatic logic [1:0] lvl_of(input logic [4:0] p, input logic [2:0] v);
    if (v == 3'd0) return 2'd3;
    return p[v - 3'd1] ? 2'd2 : 2'd1;
  endfunction

  // R6
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (vec_idx <= 3'd5));

  // R7
  vec_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (vec_idx == 3'd0));

  // R8
  grant_marks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (svc_level == lvl_of($past(prio_rdata), vec_idx)));

  // R4
  preempt_strictly_higher_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (svc_level > $past(svc_level)));

  // R4
  global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !ack);

  // R9
  level_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !$past(reti)) |-> (svc_level == $past(svc_level)));
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .glb_en     (glb_en),
  .reti       (reti),
  .prio_rdata (prio_rdata),
  .ack        (ack),
  .vec_idx    (vec_idx),
  .svc_level  (svc_level)
);

// File: tb/irq_nest_ctrl_test.sv
`timescale 1ns/1ps
module irq_nest_ctrl_test;
  logic       clk;
  logic       rst_n;
  logic       glb_en;
  logic [5:0] src_en;
  logic [5:0] flags;   // index = vector index; bit 5 routed to rx or tx
  logic       use_tx;
  logic       reti;
  logic       prio_wr;
  logic [4:0] prio_wdata;
  logic [4:0] prio_rdata;
  logic       ack;
  logic [2:0] vec_idx;
  logic [1:0] svc_level;

  int n_vec;
  int n_bad;

  // reference model state
  logic [4:0] m_prio;
  logic [2:0] m_isf;
  logic       m_ack;
  logic [2:0] m_vec;

  irq_nest_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .glb_en     (glb_en),
    .src_en     (src_en),
    .pfw_flag   (flags[0]),
    .ext0_flag  (flags[1]),
    .tmr0_flag  (flags[2]),
    .ext1_flag  (flags[3]),
    .tmr1_flag  (flags[4]),
    .rx_flag    (flags[5] & ~use_tx),
    .tx_flag    (flags[5] & use_tx),
    .reti       (reti),
    .prio_wr    (prio_wr),
    .prio_wdata (prio_wdata),
    .prio_rdata (prio_rdata),
    .ack        (ack),
    .vec_idx    (vec_idx),
    .svc_level  (svc_level)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // R3: power-fail fixed at 3, others 2 when bit set, else 1
  function automatic int lvl_of(input int i, input logic [4:0] p);
    if (i == 0) return 3;
    return p[i-1] ? 2 : 1;
  endfunction

  function automatic int top_of(input logic [2:0] f);
    if (f[2]) return 3;
    if (f[1]) return 2;
    if (f[0]) return 1;
    return 0;
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    n_vec++;
    cmp("R7 ack", int'(ack), int'(m_ack));          // R5 and R4 decide which cycles grant
    cmp("R6 vec_idx", int'(vec_idx), int'(m_vec));  // R5 level first, R6 index order
    cmp("R8 svc_level", int'(svc_level), top_of(m_isf));
    cmp("R2 prio_rdata", int'(prio_rdata), int'(m_prio));
  endtask

  // one clock: predict from current inputs, step the edge, compare after it
  task automatic step();
    int cur, best, bl, lv;
    logic [2:0] n_isf;
    cur  = top_of(m_isf);
    best = -1;
    bl   = 0;
    for (int i = 0; i < 6; i++) begin
      lv = lvl_of(i, m_prio);
      // R4 eligibility, R5 higher level wins, R6 first index wins a tie
      if (flags[i] && src_en[i] && glb_en && lv > cur && lv > bl) begin
        best = i;
        bl   = lv;
      end
    end
    n_isf = m_isf;
    if (reti) begin   // R9 retire the innermost level only
      if (n_isf[2])      n_isf[2] = 1'b0;
      else if (n_isf[1]) n_isf[1] = 1'b0;
      else if (n_isf[0]) n_isf[0] = 1'b0;
    end
    if (best >= 0) n_isf[bl-1] = 1'b1;
    @(posedge clk);
    m_isf = n_isf;
    m_ack = (best >= 0);
    m_vec = (best >= 0) ? 3'(best) : 3'd0;
    if (prio_wr) m_prio = prio_wdata;
    #2;
    check_outputs();
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0; glb_en = 1'b1; src_en = 6'h3f; flags = '0; use_tx = 1'b0;
    reti = 1'b0; prio_wr = 1'b0; prio_wdata = '0;
    m_prio = '0; m_isf = '0; m_ack = 1'b0; m_vec = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state while held
    n_vec++;
    cmp("R1 ack", int'(ack), 0);
    cmp("R1 vec_idx", int'(vec_idx), 0);
    cmp("R1 svc_level", int'(svc_level), 0);
    cmp("R1 prio_rdata", int'(prio_rdata), 0);
    rst_n = 1'b1;
    repeat (4) step();   // R1 idle after release

    // sweep: every priority setting against every simultaneous pattern
    for (int p = 0; p < 32; p++) begin
      for (int q = 0; q < 64; q++) begin
        prio_wr = 1'b1; prio_wdata = 5'(p); flags = '0;
        step();   // R2 write visible after the edge
        prio_wr = 1'b0; flags = 6'(q); use_tx = q[0] ^ p[0];
        repeat (4) step();   // held flags must not be granted twice (R4)
        flags = '0; reti = 1'b1;
        repeat (3) step();   // R9 unwind, including empty retires
        reti = 1'b0;
      end
    end

    // staggered arrivals, nesting, writes, enables
    r = 32'h1234_5678;
    for (int c = 0; c < 30000; c++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      for (int b = 0; b < 6; b++) if (r[b*3 +: 3] == 3'd0) flags[b] = ~flags[b];
      reti       = (r[20:18] == 3'd0);
      prio_wr    = (r[24:21] == 4'd0);
      prio_wdata = r[31:27];
      glb_en     = (r[26:25] != 2'd0);
      use_tx     = r[19];
      if (r[30:23] == 8'd0) src_en = r[5:0] | 6'h21;
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule